// File: doc/BRIEF.md
# Endpoint Buffer Command Port

This block is the host-facing side of a USB device controller's endpoint buffer bank. A 16-bit parallel port, together with one address line, accepts command words and then moves data words. A buffer-write command opens a session in which the host loads a packet into an endpoint buffer. The first data word holds the byte count. The words after it carry the payload two bytes at a time, and the earlier byte of each pair sits in the low half. A buffer-read command returns a stored packet in the same layout. A status command returns one status word for an endpoint and clears that endpoint's interrupt flag. Stall and unstall commands set or clear an endpoint's stall flag.

The bank holds sixteen endpoint slots. Slot 0 is the control OUT buffer, slot 1 is the control IN buffer, and slot k (2 to 15) is endpoint k-1. Slots picked by a mask parameter are double-buffered and hold a primary half and a secondary half. Word pointers are not bounded: they wrap inside the primary half. The one exception is DMA mode on a double-buffered slot, where the pointer continues from the last primary word into the secondary half. A small engine-side port stands in for the packet engine. Through it the engine writes buffer words, reports finished transactions and reports SETUP tokens.

Top module: `epb_cmd_port`

## Requirements
- R1: After reset no session is open, `hc_dout` is 0, and every endpoint's full, stall and interrupt flags are 0.
- R2: A word written with `hc_a0` = 1 is a command, and its low byte is the code. 01h–0Fh write slot = code. 10h reads slot 0. 12h–1Fh read slot = code − 10h. 50h–5Fh read the status of slot = code − 50h. 40h–4Fh stall and 60h–6Fh unstall slot = code & 0Fh. Any other code, 00h and 11h included, opens no session.
- R3: Every command write restarts the word pointer at word 0. Data words use `hc_a0` = 0.
- R4: In a buffer session, word 0 is the packet length N in bytes. Data word k carries byte 2k−1 on bits 7:0 and byte 2k on bits 15:8. A read returns exactly what was written.
- R5: A buffer session ends after M+1 words, with M = floor((N+1)/2). A status session ends after one word. While no session is open, `hc_dout` is 0.
- R6: The word that completes a buffer write sets that slot's full flag. With N = 0, the length word completes the write.
- R7: A status word reads bit 0 = full, bit 1 = stall, bit 2 = interrupt, and all other bits 0. Reading it clears the interrupt flag of that slot only.
- R8: An engine transaction report sets the slot's interrupt flag and loads its full flag from `eng_full`.
- R9: The word that completes a buffer read clears that slot's full flag.
- R10: A stall command sets the stall flag, and an unstall command or a SETUP report clears it.
- R11: With DMA off, or on a single-buffered slot, the pointer steps from word DEPTH_W−1 back to word 0. With DMA on and a double-buffered slot, it steps to word DEPTH_W of the secondary half.
- R12: Data words that arrive while no session of the matching direction is open change no buffer word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hc_a0 | input | 1 | 1 = command phase, 0 = data phase |
| hc_wr | input | 1 | Host write strobe, one word per cycle |
| hc_rd | input | 1 | Host read strobe, one word per cycle |
| hc_din | input | 16 | Host write data |
| hc_dout | output | 16 | Host read data for the current word |
| dma_mode | input | 1 | Enables primary-to-secondary pointer roll |
| eng_we | input | 1 | Engine buffer-word write |
| eng_ep | input | 4 | Engine slot select |
| eng_addr | input | PW | Engine word address inside the slot |
| eng_wdata | input | 16 | Engine write data |
| eng_done | input | 1 | Engine transaction report for `eng_ep` |
| eng_full | input | 1 | Full value carried by the report |
| eng_setup | input | 1 | SETUP token seen on `eng_ep` |
| ep_irq | output | 16 | Per-slot interrupt flags |

## Verification
On every cycle the assertions check that a command write restarts the pointer, that a status session lasts one word, and that the pointer moves into the secondary half in DMA mode. They also check that the completing write sets full, that a completing read clears it, that a status read clears only the addressed interrupt, and that a SETUP report clears stall. Only the bench scenarios can show that the payload comes back byte-exact in the packed order, that an odd length leaves the last upper byte as written, and that a wrapping pointer overwrites the length word. They also show that stray data words leave older buffer contents untouched.

// File: rtl/epb_pkg.sv
package epb_pkg;
   localparam int NEP = 16;
   localparam int EPW = 4;
   localparam int DW  = 16;

   typedef enum logic [2:0] {
      K_NONE, K_WRBUF, K_RDBUF, K_STAT, K_STALL, K_UNSTALL
   } kind_e;

   typedef struct packed {
      kind_e          kind;
      logic [EPW-1:0] ep;
   } cmd_t;

   // words after the length word: floor((n+1)/2)
   function automatic logic [DW-1:0] words_of(input logic [DW-1:0] n);
      logic [DW:0] t;
      t = {1'b0, n} + {{DW{1'b0}}, 1'b1};
      return t[DW:1];
   endfunction
endpackage

// File: rtl/epb_cmd_decode.sv
module epb_cmd_decode
   import epb_pkg::*;
(
   input  logic [7:0] code,
   output cmd_t       cmd
);
   always_comb begin
      cmd.ep   = code[3:0];
      cmd.kind = K_NONE;
      unique case (code[7:4])
         4'h0: if (code[3:0] != 4'h0) cmd.kind = K_WRBUF;
         4'h1: if (code[3:0] != 4'h1) cmd.kind = K_RDBUF;
         4'h4: cmd.kind = K_STALL;
         4'h5: cmd.kind = K_STAT;
         4'h6: cmd.kind = K_UNSTALL;
         default: cmd.kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/epb_bank.sv
module epb_bank
   import epb_pkg::*;
#(
   parameter int DEPTH_W = 16,
   parameter int PW      = 5
)(
   input  logic              clk,
   input  logic              we_a,
   input  logic [EPW+PW-1:0] addr_a,
   input  logic [DW-1:0]     wdata_a,
   input  logic              we_b,
   input  logic [EPW+PW-1:0] addr_b,
   input  logic [DW-1:0]     wdata_b,
   input  logic [EPW+PW-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   localparam int WORDS = NEP * (1 << PW);

   if ((1 << PW) != 2 * DEPTH_W) begin : g_bad_pw
      $error("epb_bank: PW does not match DEPTH_W");
   end

   logic [DW-1:0] mem [WORDS];

   // host port A is written last so it wins a same-word collision
   always_ff @(posedge clk) begin
      if (we_b) mem[addr_b] <= wdata_b;
      if (we_a) mem[addr_a] <= wdata_a;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/epb_session.sv
module epb_session
   import epb_pkg::*;
#(
   parameter int DEPTH_W = 16,
   parameter int PW      = 5
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_we,
   input  cmd_t           cmd,
   input  logic           acc,
   input  logic           dma,
   input  logic [NEP-1:0] dbl_vec,
   input  logic [DW-1:0]  len_in,
   output kind_e          kind_q,
   output logic [EPW-1:0] ep_q,
   output logic [PW-1:0]  ptr_q,
   output logic           last_acc
);
   localparam logic [PW-1:0] PRI_END = PW'(DEPTH_W - 1);
   localparam logic [PW-1:0] SEC_BEG = PW'(DEPTH_W);

   logic [DW-1:0] cnt_q, m_q, m_now;
   logic [PW-1:0] ptr_nx;
   logic          fin;

   assign m_now    = (cnt_q == '0) ? words_of(len_in) : m_q;
   assign fin      = (kind_q == K_STAT) || (cnt_q == m_now);
   assign last_acc = acc && (kind_q != K_STAT) && (cnt_q == m_now);

   always_comb begin
      if (ptr_q == PRI_END)
         ptr_nx = (dma && dbl_vec[ep_q]) ? SEC_BEG : '0;
      else
         ptr_nx = ptr_q + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_NONE;
         ep_q   <= '0;
         ptr_q  <= '0;
         cnt_q  <= '0;
         m_q    <= '0;
      end else if (cmd_we) begin
         kind_q <= (cmd.kind inside {K_WRBUF, K_RDBUF, K_STAT}) ? cmd.kind : K_NONE;
         ep_q   <= cmd.ep;
         ptr_q  <= '0;
         cnt_q  <= '0;
         m_q    <= '0;
      end else if (acc) begin
         ptr_q <= ptr_nx;
         cnt_q <= cnt_q + DW'(1);
         if (cnt_q == '0) m_q <= m_now;
         if (fin) kind_q <= K_NONE;
      end
   end

   a_r3_cmd_restarts_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> (ptr_q == '0) && (cnt_q == '0));

   a_r5_status_one_word: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && kind_q == K_STAT) |=> (kind_q == K_NONE));

   a_r11_dma_roll: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cmd_we && ptr_q == PRI_END && dma && dbl_vec[ep_q]) |=> (ptr_q == SEC_BEG));
endmodule

// File: rtl/epb_status.sv
module epb_status
   import epb_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [EPW-1:0] hep,
   input  logic           wr_done,
   input  logic           rd_done,
   input  logic           stat_rd,
   input  logic [EPW-1:0] cep,
   input  logic           stall_set,
   input  logic           stall_clr,
   input  logic [EPW-1:0] eng_ep,
   input  logic           eng_done,
   input  logic           eng_full,
   input  logic           eng_setup,
   output logic [NEP-1:0] full_o,
   output logic [NEP-1:0] stall_o,
   output logic [NEP-1:0] irq_o
);
   for (genvar e = 0; e < NEP; e++) begin : g_ep
      localparam logic [EPW-1:0] ID = EPW'(e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_o[e]  <= 1'b0;
            stall_o[e] <= 1'b0;
            irq_o[e]   <= 1'b0;
         end else begin
            if (eng_done && eng_ep == ID)    irq_o[e] <= 1'b1;
            else if (stat_rd && hep == ID)   irq_o[e] <= 1'b0;

            if (wr_done && hep == ID)        full_o[e] <= 1'b1;
            else if (rd_done && hep == ID)   full_o[e] <= 1'b0;
            else if (eng_done && eng_ep == ID) full_o[e] <= eng_full;

            if (eng_setup && eng_ep == ID)   stall_o[e] <= 1'b0;
            else if (stall_set && cep == ID) stall_o[e] <= 1'b1;
            else if (stall_clr && cep == ID) stall_o[e] <= 1'b0;
         end
      end
   end

   a_r7_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !(eng_done && eng_ep == hep)) |=> !irq_o[$past(hep)]);

   a_r10_setup_unstalls: assert property (@(posedge clk) disable iff (!rst_n)
      eng_setup |=> !stall_o[$past(eng_ep)]);
endmodule

// File: rtl/epb_cmd_port.sv
module epb_cmd_port
   import epb_pkg::*;
#(
   parameter int          DEPTH_W  = 16,
   parameter logic [15:0] DBL_MASK = 16'h0030,
   localparam int         PW       = $clog2(2 * DEPTH_W)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hc_a0,
   input  logic          hc_wr,
   input  logic          hc_rd,
   input  logic [15:0]   hc_din,
   output logic [15:0]   hc_dout,
   input  logic          dma_mode,
   input  logic          eng_we,
   input  logic [3:0]    eng_ep,
   input  logic [PW-1:0] eng_addr,
   input  logic [15:0]   eng_wdata,
   input  logic          eng_done,
   input  logic          eng_full,
   input  logic          eng_setup,
   output logic [15:0]   ep_irq
);
   if (DEPTH_W < 2 || DEPTH_W > 128 || (DEPTH_W & (DEPTH_W - 1)) != 0) begin : g_bad_depth
      $error("epb_cmd_port: DEPTH_W must be a power of two in 2..128");
   end

   cmd_t           cmd;
   kind_e          kind_q;
   logic [EPW-1:0] ep_q;
   logic [PW-1:0]  ptr_q;
   logic           last_acc, cmd_we, data_wr, data_rd, acc;
   logic [DW-1:0]  mem_rd, len_in;
   logic [NEP-1:0] full_v, stall_v, irq_v;

   assign cmd_we  = hc_wr && hc_a0;
   assign data_wr = hc_wr && !hc_a0 && (kind_q == K_WRBUF);
   assign data_rd = hc_rd && !hc_a0 && (kind_q == K_RDBUF || kind_q == K_STAT);
   assign acc     = data_wr || data_rd;
   assign len_in  = (kind_q == K_WRBUF) ? hc_din : mem_rd;

   epb_cmd_decode u_dec (
      .code (hc_din[7:0]),
      .cmd  (cmd)
   );

   epb_session #(.DEPTH_W(DEPTH_W), .PW(PW)) u_ses (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd      (cmd),
      .acc      (acc),
      .dma      (dma_mode),
      .dbl_vec  (DBL_MASK),
      .len_in   (len_in),
      .kind_q   (kind_q),
      .ep_q     (ep_q),
      .ptr_q    (ptr_q),
      .last_acc (last_acc)
   );

   epb_bank #(.DEPTH_W(DEPTH_W), .PW(PW)) u_bank (
      .clk     (clk),
      .we_a    (data_wr),
      .addr_a  ({ep_q, ptr_q}),
      .wdata_a (hc_din),
      .we_b    (eng_we),
      .addr_b  ({eng_ep, eng_addr}),
      .wdata_b (eng_wdata),
      .raddr   ({ep_q, ptr_q}),
      .rdata   (mem_rd)
   );

   epb_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .hep       (ep_q),
      .wr_done   (data_wr && last_acc),
      .rd_done   (data_rd && last_acc),
      .stat_rd   (data_rd && kind_q == K_STAT),
      .cep       (cmd.ep),
      .stall_set (cmd_we && cmd.kind == K_STALL),
      .stall_clr (cmd_we && cmd.kind == K_UNSTALL),
      .eng_ep    (eng_ep),
      .eng_done  (eng_done),
      .eng_full  (eng_full),
      .eng_setup (eng_setup),
      .full_o    (full_v),
      .stall_o   (stall_v),
      .irq_o     (irq_v)
   );

   always_comb begin
      unique case (kind_q)
         K_RDBUF: hc_dout = mem_rd;
         K_STAT:  hc_dout = {13'd0, irq_v[ep_q], stall_v[ep_q], full_v[ep_q]};
         default: hc_dout = '0;
      endcase
   end

   assign ep_irq = irq_v;

   a_r6_write_end_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && last_acc) |=> full_v[$past(ep_q)]);

   a_r9_read_end_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && last_acc) |=> !full_v[$past(ep_q)]);

   a_r1_idle_dout_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_NONE) |-> (hc_dout == 16'd0));
endmodule

// File: tb/sim_epb_cmd_port.sv
module sim_epb_cmd_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hc_a0 = 1'b0, hc_wr = 1'b0, hc_rd = 1'b0;
   logic [15:0] hc_din = '0;
   logic [15:0] hc_dout;
   logic        dma_mode = 1'b0;
   logic        eng_we = 1'b0;
   logic [3:0]  eng_ep = '0;
   logic [4:0]  eng_addr = '0;
   logic [15:0] eng_wdata = '0;
   logic        eng_done = 1'b0, eng_full = 1'b0, eng_setup = 1'b0;
   logic [15:0] ep_irq;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   epb_cmd_port u0 (.*);

   // {write code, read code, length, byte seed}
   localparam logic [31:0] VEC [6] = '{
      32'h02_12_01_10, 32'h07_17_02_20, 32'h09_19_05_31,
      32'h0F_1F_1E_47, 32'h08_18_00_55, 32'h0C_1C_09_63 };

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] byt(input int i, input logic [7:0] seed, input int n);
      return (i <= n) ? 8'(seed + 8'(3 * i)) : 8'h00;
   endfunction

   function automatic logic [15:0] pword(input int k, input logic [7:0] seed, input int n);
      return {byt(2 * k, seed, n), byt(2 * k - 1, seed, n)};
   endfunction

   task automatic cmd(input logic [7:0] c);
      @(negedge clk); hc_a0 = 1'b1; hc_wr = 1'b1; hc_din = {8'hA5, c};
      @(negedge clk); hc_wr = 1'b0; hc_a0 = 1'b0;
   endtask

   task automatic dwr(input logic [15:0] d);
      @(negedge clk); hc_a0 = 1'b0; hc_wr = 1'b1; hc_din = d;
      @(negedge clk); hc_wr = 1'b0;
   endtask

   task automatic drd(output logic [15:0] d);
      @(negedge clk); hc_a0 = 1'b0; hc_rd = 1'b1;
      #1 d = hc_dout;
      @(negedge clk); hc_rd = 1'b0;
   endtask

   task automatic put_pkt(input logic [7:0] code, input int n, input logic [7:0] seed);
      cmd(code);
      dwr(16'(n));
      for (int k = 1; k <= (n + 1) / 2; k++) dwr(pword(k, seed, n));
   endtask

   task automatic stat(input logic [3:0] ep, input logic [15:0] exp, input string req);
      logic [15:0] d;
      cmd({4'h5, ep});
      drd(d);
      chk(d == exp, req, d, exp);
   endtask

   task automatic eng_evt(input logic [3:0] ep, input logic full, input logic setup);
      @(negedge clk); eng_ep = ep; eng_done = !setup; eng_full = full; eng_setup = setup;
      @(negedge clk); eng_done = 1'b0; eng_setup = 1'b0;
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(hc_dout == 16'd0, "R1 dout", hc_dout, 16'd0);
      chk(ep_irq == 16'd0, "R1 irq", ep_irq, 16'd0);
      stat(4'd5, 16'h0000, "R1 flags");
      // R12: data with no session
      dwr(16'h1234); drd(d);
      chk(d == 16'd0, "R12 no session", d, 16'd0);

      // vector table: R4 round trip, R5 end, R6 full, R9 cleared
      for (int v = 0; v < 6; v++) begin
         logic [7:0] wc, rc, sd;
         int n;
         wc = VEC[v][31:24]; rc = VEC[v][23:16]; n = int'(VEC[v][15:8]); sd = VEC[v][7:0];
         put_pkt(wc, n, sd);
         stat(wc[3:0], 16'h0001, "R6 full after write");
         cmd(rc);
         drd(d); chk(d == 16'(n), "R4 length", d, 16'(n));
         for (int k = 1; k <= (n + 1) / 2; k++) begin
            drd(d); chk(d == pword(k, sd, n), "R4 payload", d, pword(k, sd, n));
         end
         drd(d); chk(d == 16'd0, "R5 session over", d, 16'd0);
         stat(wc[3:0], 16'h0000, "R9 full cleared");
      end

      // R2: invalid codes open nothing
      cmd(8'h11); drd(d); chk(d == 16'd0, "R2 code 11h", d, 16'd0);
      cmd(8'h00); dwr(16'hBEEF); drd(d); chk(d == 16'd0, "R2 code 00h", d, 16'd0);

      // R5/R12: extra word after a finished write is ignored
      put_pkt(8'h06, 8, 8'h70);
      put_pkt(8'h06, 3, 8'h90);
      dwr(16'hDEAD);
      @(negedge clk); eng_we = 1'b1; eng_ep = 4'd6; eng_addr = 5'd0; eng_wdata = 16'd8;
      @(negedge clk); eng_we = 1'b0;
      cmd(8'h16);
      drd(d); chk(d == 16'd8, "R12 engine length", d, 16'd8);
      drd(d); chk(d == pword(1, 8'h90, 3), "R4 new word1", d, pword(1, 8'h90, 3));
      drd(d); chk(d == pword(2, 8'h90, 3), "R4 odd last word", d, pword(2, 8'h90, 3));
      drd(d); chk(d == pword(3, 8'h70, 8), "R12 stray word ignored", d, pword(3, 8'h70, 8));
      drd(d); chk(d == pword(4, 8'h70, 8), "R5 old word4", d, pword(4, 8'h70, 8));

      // R11: single-buffered wrap overwrites the length word
      put_pkt(8'h03, 34, 8'h11);
      stat(4'd3, 16'h0001, "R6 full after wrap write");
      cmd(8'h13); drd(d);
      chk(d == pword(16, 8'h11, 34), "R11 wrap to word 0", d, pword(16, 8'h11, 34));
      cmd(8'h00);

      // R11: DMA on a double-buffered slot rolls into the secondary half
      dma_mode = 1'b1;
      put_pkt(8'h04, 34, 8'h22);
      cmd(8'h14);
      drd(d); chk(d == 16'd34, "R11 length kept", d, 16'd34);
      for (int k = 1; k <= 17; k++) begin
         drd(d); chk(d == pword(k, 8'h22, 34), "R11 secondary data", d, pword(k, 8'h22, 34));
      end
      dma_mode = 1'b0;
      cmd(8'h14);
      for (int k = 0; k <= 15; k++) drd(d);
      drd(d); chk(d == 16'd34, "R11 no DMA wraps", d, 16'd34);
      // R3: new command restarts at word 0
      cmd(8'h14); drd(d); chk(d == 16'd34, "R3 restart", d, 16'd34);

      // R7/R8: interrupts and status clearing
      eng_evt(4'd7, 1'b1, 1'b0);
      eng_evt(4'd8, 1'b0, 1'b0);
      chk(ep_irq == 16'h0180, "R8 irq set", ep_irq, 16'h0180);
      stat(4'd7, 16'h0005, "R7 status word");
      chk(ep_irq == 16'h0100, "R7 only slot cleared", ep_irq, 16'h0100);
      stat(4'd7, 16'h0001, "R7 second read");
      stat(4'd8, 16'h0004, "R8 full from report");
      chk(ep_irq == 16'h0000, "R7 all clear", ep_irq, 16'h0000);
      eng_evt(4'd7, 1'b0, 1'b0);
      stat(4'd7, 16'h0004, "R8 report clears full");

      // R10: stall handling
      cmd(8'h4A); stat(4'd10, 16'h0002, "R10 stall set");
      cmd(8'h6A); stat(4'd10, 16'h0000, "R10 unstall");
      cmd(8'h4A); eng_evt(4'd10, 1'b0, 1'b1);
      stat(4'd10, 16'h0000, "R10 setup clears");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule